// File: doc/BRIEF.md
# Big-Endian Multi-Size Byte Memory Accessor

This block moves an 8-, 16- or 32-bit quantity between a CPU-side register and a byte-wide synchronous RAM addressed by 16 bits. Multi-byte values are laid out most significant byte first, at increasing addresses. One command starts a transfer. The sequencer then issues one RAM access per clock and raises a one-cycle completion strobe.

The accessor serves peek/poke requests and indexed array elements. In index mode the incoming operand is an element number. It is scaled by the element size of the build (4 bytes when the register is 32 bits wide, 2 bytes when it is 16) and added to the first free byte, which is the location one past the end of the program area. A double-word store swaps the halves of its working copy, emits two bytes, swaps back and emits two more. It then steps the address back by three and reads the four bytes back, so the stored value is returned as the result.

The parameter `DATA_W` selects a 16- or 32-bit build. The RAM side stays 16-bit address and 8-bit data in both builds.

Top module: `bemem_accessor`

## Requirements
- R1: A command is accepted only while `busy` is low and `cmd_valid` is high. Codes are 20 (read 1 byte), 21 (read 2 bytes), 22 (read 4 bytes), 24 (write 1 byte), 25 (write 2 bytes) and 26 (write 4 bytes). Any other code starts nothing: `busy` and `ram_en` stay low.
- R2: A byte write performs one RAM write of `wr_value[7:0]` at the start address.
- R3: A byte read performs one RAM read and returns the byte in `rd_value[7:0]`, with every higher bit zero.
- R4: A word write stores `wr_value[15:8]` at the start address, then `wr_value[7:0]` at the next address. Bits above 15 are not stored.
- R5: A word read returns the byte at the start address in bits 15..8 and the next byte in bits 7..0, with every higher bit zero.
- R6: In the 32-bit build, a double-word write stores bits 31..24, 23..16, 15..8 and 7..0 at four increasing addresses, in that order.
- R7: A double-word write continues with four reads. The first read address is the last written address minus 3. The result in `rd_value` equals the value just stored.
- R8: A double-word read performs four reads at increasing addresses. It shifts `rd_value` left by 8 and inserts each new byte at the bottom, so the first byte ends up most significant.
- R9: With `cmd_use_index` high, the start address is `prog_end + 1 + (cmd_addr << 2)` in the 32-bit build and `prog_end + 1 + (cmd_addr << 1)` in the 16-bit build.
- R10: All address arithmetic wraps modulo 65536.
- R11: Accesses occur on consecutive cycles, starting the cycle after acceptance. `done` is high for exactly one cycle. For a command with no reads, that cycle comes right after the last write. For a command that ends in reads, it comes two cycles after the last read, and `rd_value` is final in that cycle.
- R12: `cmd_valid` is ignored while `busy` is high. `rd_value` changes only while `busy` or `done` is high, so byte and word writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 5 | Transfer code (size and direction) |
| cmd_use_index | input | 1 | Treat `cmd_addr` as an array element number |
| cmd_addr | input | 16 | Byte address, or element number in index mode |
| prog_end | input | 16 | Last byte of the program area |
| wr_value | input | DATA_W | Value to store |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_value | output | DATA_W | Value read or returned |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM byte address |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, valid one cycle after the read |

## Verification
The bench checks the RAM port cycle by cycle against a behavioural model. It targets the following corner cases:

- **Byte order:** a design that stored low byte first would show swapped bytes on `ram_wdata`.
- **Zero extension:** a design that failed to zero-extend would leave stale upper bits from an earlier double-word in a later byte or word read.
- **Double-word store:** this is aimed at the half-swap order and the rewind by three. A missing swap would emit bytes 15..0 twice. A wrong rewind would read back from the wrong address and return a mismatched result.
- **Index scaling, address wrap and busy-time requests:** a one-bit index shift would land on the wrong element, wrap at address 0xFFFF must be correct, and a command held during a busy transfer must not restart the sequence or corrupt it.

// File: rtl/bemem_pkg.sv
package bemem_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WR   = 2'd1,
        PH_RD   = 2'd2,
        PH_FIN  = 2'd3
    } phase_e;

    // Transfer size in bytes for a command code, 0 for an unknown code.
    function automatic logic [2:0] code_bytes(input logic [4:0] code);
        case (code)
            5'd20, 5'd24: code_bytes = 3'd1;
            5'd21, 5'd25: code_bytes = 3'd2;
            5'd22, 5'd26: code_bytes = 3'd4;
            default:      code_bytes = 3'd0;
        endcase
    endfunction

    // Store codes (24..26) differ from load codes (20..22) in bit 3.
    function automatic logic code_is_write(input logic [4:0] code);
        code_is_write = code[3];
    endfunction

endpackage

// File: rtl/bemem_addr_gen.sv
module bemem_addr_gen #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic              use_index,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [ADDR_W-1:0] prog_end,
    output logic [ADDR_W-1:0] addr_out
);
    // Element size is 4 bytes in the wide build, 2 bytes in the narrow one.
    localparam int ELEM_SHIFT = (DATA_W >= 32) ? 2 : 1;

    logic [ADDR_W-1:0] first_free;
    logic [ADDR_W-1:0] offset;

    assign first_free = prog_end + ADDR_W'(1);
    assign offset     = addr_in << ELEM_SHIFT;
    assign addr_out   = use_index ? (first_free + offset) : addr_in;
endmodule

// File: rtl/bemem_half_swap.sv
module bemem_half_swap #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int HALF_W = DATA_W / 2;

    generate
        if (DATA_W > 16) begin : g_swap
            assign dout = {din[HALF_W-1:0], din[DATA_W-1:HALF_W]};
        end else begin : g_pass
            // Narrow build: the register is a single word, so no swap is done.
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/bemem_accessor.sv
module bemem_accessor
    import bemem_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [4:0]        cmd_code,
    input  logic              cmd_use_index,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] prog_end,
    input  logic [DATA_W-1:0] wr_value,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_value,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata
);
    localparam int BYTE_W = 8;
    localparam int KEEP_W = DATA_W - BYTE_W;

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] ptr;      // address of the current access
        logic [2:0]        cnt;      // accesses left in this phase
        logic [1:0]        step;     // write step, odd = low byte
        logic              readback; // reads follow the writes
        logic              cap;      // a read was issued last cycle
        logic              done;
        logic [DATA_W-1:0] work;     // working copy of the store value
        logic [DATA_W-1:0] rd;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0] start_addr;
    logic [DATA_W-1:0] in_swapped;
    logic [DATA_W-1:0] work_swapped;
    logic [2:0]        cmd_bytes;
    logic              cmd_wr;

    assign cmd_bytes = code_bytes(cmd_code);
    assign cmd_wr    = code_is_write(cmd_code);

    bemem_addr_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
        .use_index (cmd_use_index),
        .addr_in   (cmd_addr),
        .prog_end  (prog_end),
        .addr_out  (start_addr)
    );

    bemem_half_swap #(.DATA_W(DATA_W)) u_swap_in (
        .din  (wr_value),
        .dout (in_swapped)
    );

    bemem_half_swap #(.DATA_W(DATA_W)) u_swap_work (
        .din  (st_q.work),
        .dout (work_swapped)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.cap  = 1'b0;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = st_q.ptr;
        ram_wdata = st_q.work[15:8];

        // Byte returned by the RAM for last cycle's read enters at the bottom.
        if (st_q.cap) begin
            st_d.rd = {st_q.rd[KEEP_W-1:0], ram_rdata};
        end

        unique case (st_q.phase)
            PH_IDLE: begin
                if (cmd_valid && (cmd_bytes != 3'd0)) begin
                    st_d.ptr  = start_addr;
                    st_d.cnt  = cmd_bytes;
                    st_d.step = 2'd0;
                    if (cmd_wr) begin
                        st_d.phase    = PH_WR;
                        st_d.readback = (cmd_bytes == 3'd4);
                        if (cmd_bytes == 3'd4) begin
                            st_d.work = in_swapped;
                        end else if (cmd_bytes == 3'd1) begin
                            // Single byte is parked in the high-byte slot of step 0.
                            st_d.work = wr_value << BYTE_W;
                        end else begin
                            st_d.work = wr_value;
                        end
                    end else begin
                        st_d.phase    = PH_RD;
                        st_d.readback = 1'b0;
                        st_d.rd       = '0;
                    end
                end
            end
            PH_WR: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_wdata = st_q.step[0] ? st_q.work[7:0] : st_q.work[15:8];
                st_d.step = st_q.step + 2'd1;
                if (st_q.step[0]) begin
                    st_d.work = work_swapped;
                end
                st_d.cnt = st_q.cnt - 3'd1;
                if (st_q.cnt == 3'd1) begin
                    if (st_q.readback) begin
                        st_d.phase = PH_RD;
                        st_d.ptr   = st_q.ptr - ADDR_W'(3);
                        st_d.cnt   = 3'd4;
                        st_d.rd    = '0;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end
                end else begin
                    st_d.ptr = st_q.ptr + ADDR_W'(1);
                end
            end
            PH_RD: begin
                ram_en   = 1'b1;
                st_d.cap = 1'b1;
                st_d.cnt = st_q.cnt - 3'd1;
                if (st_q.cnt == 3'd1) begin
                    st_d.phase = PH_FIN;
                end else begin
                    st_d.ptr = st_q.ptr + ADDR_W'(1);
                end
            end
            PH_FIN: begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.phase != PH_IDLE);
    assign done     = st_q.done;
    assign rd_value = st_q.rd;

    // R11: completion strobe lasts one cycle.
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: no RAM traffic while no transfer is running.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ram_en);

    // R6: back-to-back writes walk upward by one byte.
    p_write_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && ram_we && $past(ram_en && ram_we)) |->
        (ram_addr == $past(ram_addr) + ADDR_W'(1)));

    // R7: the readback starts three below the last written address.
    p_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_we && $past(ram_en && ram_we)) |->
        (ram_addr == $past(ram_addr) - ADDR_W'(3)));

    // R8: back-to-back reads walk upward by one byte.
    p_read_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_we && $past(ram_en && !ram_we)) |->
        (ram_addr == $past(ram_addr) + ADDR_W'(1)));

    // R12: the result register moves only during a transfer or its strobe.
    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_value) |-> (busy || done));
endmodule

// File: tb/bemem_accessor_tb.sv
module bemem_accessor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    typedef struct {
        bit          we;
        logic [15:0] a;
        logic [7:0]  d;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [4:0]  cmd_code = '0;
    logic        cmd_use_index = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] prog_end = '0;
    logic [DW-1:0] wr_value = '0;
    logic        busy, done;
    logic [DW-1:0] rd_value;
    logic        ram_en, ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_q = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] exp_rd = '0;
    logic [7:0] mem [int];

    always #(CLK_PERIOD / 2) clk = ~clk;

    bemem_accessor #(.DATA_W(DW), .ADDR_W(16)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_code      (cmd_code),
        .cmd_use_index (cmd_use_index),
        .cmd_addr      (cmd_addr),
        .prog_end      (prog_end),
        .wr_value      (wr_value),
        .busy          (busy),
        .done          (done),
        .rd_value      (rd_value),
        .ram_en        (ram_en),
        .ram_we        (ram_we),
        .ram_addr      (ram_addr),
        .ram_wdata     (ram_wdata),
        .ram_rdata     (ram_q)
    );

    function automatic logic [7:0] peek_mem(input int a);
        if (mem.exists(a)) return mem[a];
        return 8'h00;
    endfunction

    // Byte-wide synchronous RAM model.
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[int'(ram_addr)] = ram_wdata;
            else        ram_q <= peek_mem(int'(ram_addr));
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Runs one command and checks the RAM port every cycle against the model.
    task automatic run_cmd(input logic [4:0] code, input logic [15:0] a,
                           input bit idx, input logic [31:0] v,
                           input bit hold, input string tag);
        acc_t q[$];
        logic [15:0] eff;
        int n;
        bit wr;
        eff = idx ? 16'(prog_end + 16'd1 + (a << 2)) : a;
        wr  = code[3];
        n   = (code[1:0] == 2'd0) ? 1 : (code[1:0] == 2'd1) ? 2 : 4;
        if (wr) begin
            if (n == 1) q.push_back('{1'b1, eff, v[7:0]});
            if (n == 2) begin
                q.push_back('{1'b1, eff, v[15:8]});
                q.push_back('{1'b1, 16'(eff + 1), v[7:0]});
            end
            if (n == 4) begin
                for (int i = 0; i < 4; i++)
                    q.push_back('{1'b1, 16'(eff + i), v[31 - 8*i -: 8]});
                for (int i = 0; i < 4; i++)
                    q.push_back('{1'b0, 16'(eff + i), 8'h00});
                exp_rd = v;
            end
        end else begin
            exp_rd = '0;
            for (int i = 0; i < n; i++) begin
                q.push_back('{1'b0, 16'(eff + i), 8'h00});
                exp_rd = {exp_rd[23:0], peek_mem(int'(16'(eff + i)))};
            end
        end
        cmd_code = code; cmd_addr = a; cmd_use_index = idx; wr_value = v;
        cmd_valid = 1'b1;
        @(negedge clk);
        if (hold) begin
            cmd_code = 5'd20; cmd_addr = 16'h1234;
        end else begin
            cmd_valid = 1'b0;
        end
        for (int i = 0; i < q.size(); i++) begin
            chk(ram_en === 1'b1 && ram_we === q[i].we && ram_addr === q[i].a &&
                (!q[i].we || ram_wdata === q[i].d) && busy === 1'b1 && done === 1'b0,
                tag, $sformatf("access %0d addr/data", i),
                {7'd0, ram_we, ram_addr, ram_wdata},
                {7'd0, q[i].we, q[i].a, q[i].d});
            @(negedge clk);
            if (i == 1) cmd_valid = 1'b0;
        end
        if (!q[q.size()-1].we) begin
            chk(ram_en === 1'b0 && done === 1'b0, tag, "gap before done",
                {30'd0, ram_en, done}, 32'd0);
            @(negedge clk);
        end
        chk(done === 1'b1 && rd_value === exp_rd, tag, "done and result",
            rd_value, exp_rd);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R11", "done single pulse",
            {30'd0, busy, done}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL R11 watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && ram_en === 1'b0 && rd_value === '0,
            "R11", "reset state", rd_value, 32'd0);

        run_cmd(5'd25, 16'h0100, 1'b0, 32'hDEADBEEF, 1'b0, "R4");
        run_cmd(5'd21, 16'h0100, 1'b0, 32'h0, 1'b0, "R5");
        run_cmd(5'd24, 16'h0200, 1'b0, 32'hA5A5A5C3, 1'b0, "R2");
        run_cmd(5'd26, 16'h0300, 1'b0, 32'h12345678, 1'b0, "R6");
        run_cmd(5'd20, 16'h0200, 1'b0, 32'h0, 1'b0, "R3");
        run_cmd(5'd20, 16'h0101, 1'b0, 32'h0, 1'b0, "R3");
        run_cmd(5'd22, 16'h0300, 1'b0, 32'h0, 1'b0, "R8");
        run_cmd(5'd22, 16'h00FF, 1'b0, 32'h0, 1'b0, "R8");
        run_cmd(5'd26, 16'h0500, 1'b0, 32'h89ABCDEF, 1'b0, "R7");
        run_cmd(5'd21, 16'h0502, 1'b0, 32'h0, 1'b0, "R5");

        prog_end = 16'h0400;
        run_cmd(5'd26, 16'd3, 1'b1, 32'hCAFEF00D, 1'b0, "R9");
        run_cmd(5'd22, 16'h040D, 1'b0, 32'h0, 1'b0, "R9");

        run_cmd(5'd25, 16'hFFFF, 1'b0, 32'h0000ABCD, 1'b0, "R10");
        run_cmd(5'd21, 16'hFFFF, 1'b0, 32'h0, 1'b0, "R10");
        prog_end = 16'hFFF0;
        run_cmd(5'd24, 16'd5, 1'b1, 32'h0000005A, 1'b0, "R10");
        run_cmd(5'd20, 16'h0005, 1'b0, 32'h0, 1'b0, "R10");

        run_cmd(5'd26, 16'h0600, 1'b0, 32'h0BADF00D, 1'b1, "R12");
        run_cmd(5'd24, 16'h0700, 1'b0, 32'h000000EE, 1'b0, "R12");

        cmd_code = 5'd23; cmd_addr = 16'h0100; cmd_use_index = 1'b0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy === 1'b0 && ram_en === 1'b0, "R1", "unknown code ignored",
            {30'd0, busy, ram_en}, 32'd0);
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && rd_value === exp_rd, "R1",
            "unknown code leaves result", rd_value, exp_rd);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule